// File: doc/BRIEF.md
# ADC Burst Capture Buffer

This block records a single burst of 16-bit conversions from a parallel ADC and holds them until a slow microcontroller collects them. A start command from the host launches a capture: an internal divider on the system clock produces the ADC convert pulse at one of two rates, and a fixed number of cycles after each pulse the ADC data bus is written into an on-chip word FIFO. Capture ends by itself once the FIFO is full. A busy flag stays high for the whole capture and falls when the buffer is ready.

The host then drains the buffer over an 8-bit bus with a read strobe. Each rising edge of the strobe presents the next byte, high byte of a word first and then its low byte. The word leaves the FIFO only after its low byte has gone out. Reads from an empty buffer return zero and leave the FIFO alone. A new start discards whatever the host has not read yet.

Top module: `adc_burst_buf`

## Requirements
- R1: After reset busy_o is 0, adc_conv_o is 0, host_data_o is 0x00 and the FIFO is empty, so the first read strobe returns 0x00.
- R2: start_i high while busy_o is 0 raises busy_o on the next clock and starts the first convert pulse in that same cycle.
- R3: adc_conv_o is one clock wide. During a capture it repeats every DIV_FAST clocks when rate_sel_i was 1 at start and every DIV_SLOW clocks when it was 0. rate_sel_i is sampled only at start.
- R4: adc_data_i is stored LATCH_DLY clocks after each convert pulse. Words are stored in arrival order.
- R5: A capture issues exactly DEPTH convert pulses. busy_o falls one clock after the FIFO fills, and no convert pulse appears while busy_o is 0.
- R6: start_i is ignored while busy_o is 1. The capture goes on without a restart or a flush.
- R7: Each rising edge of rd_stb_i, sampled on clk_i while busy_o is 0, loads host_data_o on that clock edge. Bytes alternate between bits 15:8 and bits 7:0 of the FIFO head word, high byte first. The head word is popped after its low byte.
- R8: A read strobe while the FIFO is empty drives host_data_o to 0x00 and pops nothing, so the FIFO never underflows.
- R9: Read strobes while busy_o is 1 are ignored: host_data_o holds and the byte order is not disturbed.
- R10: An accepted start flushes unread words and resets the byte order, so the next drain begins with the high byte of the first new sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Capture start command from the host |
| rate_sel_i | input | 1 | Rate select: 1 = fast divider, 0 = slow divider |
| busy_o | output | 1 | High during capture |
| adc_conv_o | output | 1 | ADC convert pulse |
| adc_data_i | input | 16 | ADC parallel result |
| rd_stb_i | input | 1 | Host read strobe, acts on its rising edge |
| host_data_o | output | 8 | Byte presented to the host |

## Verification
The bound checker watches, on every clock, that the convert pulse is one cycle wide and keeps the selected period, that an accepted start raises busy with an empty FIFO and a convert pulse, and that busy falls right after the FIFO fills. It also checks that the FIFO never exceeds its depth, that nothing is popped from it while it is empty, and that the host byte holds during capture. The data values, their byte order, the pulse count per burst, the ignored mid-capture start and the flush of a partly read buffer only show up in the bench's scenarios, which sweep both rates and several data patterns and drain a small buffer completely.

// File: rtl/adc_buf_pkg.sv
package adc_buf_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_CAPT = 1'b1
  } cap_state_t;
endpackage

// File: rtl/adc_tick_gen.sv
module adc_tick_gen #(
  parameter int DIV_SLOW  = 100,
  parameter int DIV_FAST  = 50,
  parameter int LATCH_DLY = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic fast_i,
  output logic conv_o,
  output logic latch_o
);
  localparam int MAXD = (DIV_SLOW > DIV_FAST) ? DIV_SLOW : DIV_FAST;
  localparam int CW   = $clog2(MAXD + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim;

  assign lim = fast_i ? CW'(DIV_FAST - 1) : CW'(DIV_SLOW - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (!run_i)         cnt_q <= '0;
    else if (cnt_q == lim)   cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end

  assign conv_o  = run_i && (cnt_q == '0);
  assign latch_o = run_i && (cnt_q == CW'(LATCH_DLY));
endmodule

// File: rtl/adc_word_fifo.sv
module adc_word_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 1024
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       flush_i,
  input  logic                       push_i,
  input  logic [W-1:0]               din_i,
  input  logic                       pop_i,
  output logic [W-1:0]               head_o,
  output logic                       full_o,
  output logic                       empty_o,
  output logic [$clog2(DEPTH+1)-1:0] count_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign head_o  = mem_q[rd_ptr_q];
  assign count_o = cnt_q;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_ptr_q] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else if (flush_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (do_push) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (do_pop)  rd_ptr_q <= ptr_inc(rd_ptr_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/host_byte_mux.sv
module host_byte_mux #(
  parameter int W = 16,
  parameter int B = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clear_i,
  input  logic         en_i,
  input  logic         stb_i,
  input  logic [W-1:0] word_i,
  input  logic         empty_i,
  output logic [B-1:0] data_o,
  output logic         pop_o
);
  localparam int NB = W / B;
  localparam int BW = (NB > 1) ? $clog2(NB) : 1;

  logic          stb_q;
  logic [BW-1:0] beat_q;
  logic          take;
  logic [B-1:0]  sel_byte;

  assign take  = en_i && stb_i && !stb_q;
  assign pop_o = take && !empty_i && (beat_q == BW'(NB - 1));

  // beat 0 is the most significant byte
  always_comb begin
    sel_byte = '0;
    for (int i = 0; i < NB; i++) begin
      if (beat_q == BW'(i)) sel_byte = word_i[W-1-i*B -: B];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stb_q  <= 1'b0;
      beat_q <= '0;
      data_o <= '0;
    end else begin
      stb_q <= stb_i;
      if (clear_i) begin
        beat_q <= '0;
      end else if (take) begin
        if (empty_i) begin
          data_o <= '0;
        end else begin
          data_o <= sel_byte;
          beat_q <= (beat_q == BW'(NB - 1)) ? '0 : beat_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/adc_burst_buf.sv
module adc_burst_buf
  import adc_buf_pkg::*;
#(
  parameter int SAMPLE_W  = 16,
  parameter int HOST_W    = 8,
  parameter int DEPTH     = 1024,
  parameter int DIV_SLOW  = 100,
  parameter int DIV_FAST  = 50,
  parameter int LATCH_DLY = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic                rate_sel_i,
  output logic                busy_o,
  output logic                adc_conv_o,
  input  logic [SAMPLE_W-1:0] adc_data_i,
  input  logic                rd_stb_i,
  output logic [HOST_W-1:0]   host_data_o
);
  localparam int CW = $clog2(DEPTH + 1);

  cap_state_t          state_q;
  logic                rate_q;
  logic                start_go;
  logic                latch;
  logic                fifo_push, fifo_pop;
  logic                fifo_full, fifo_empty;
  logic [SAMPLE_W-1:0] fifo_head;
  logic [CW-1:0]       fifo_count;

  assign busy_o    = (state_q == ST_CAPT);
  assign start_go  = (state_q == ST_IDLE) && start_i;
  assign fifo_push = busy_o && latch && !fifo_full;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      rate_q  <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_CAPT;
          rate_q  <= rate_sel_i;
        end
        ST_CAPT: if (fifo_full) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  adc_tick_gen #(
    .DIV_SLOW (DIV_SLOW),
    .DIV_FAST (DIV_FAST),
    .LATCH_DLY(LATCH_DLY)
  ) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (busy_o),
    .fast_i (rate_q),
    .conv_o (adc_conv_o),
    .latch_o(latch)
  );

  adc_word_fifo #(
    .W    (SAMPLE_W),
    .DEPTH(DEPTH)
  ) u_fifo (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .flush_i(start_go),
    .push_i (fifo_push),
    .din_i  (adc_data_i),
    .pop_i  (fifo_pop),
    .head_o (fifo_head),
    .full_o (fifo_full),
    .empty_o(fifo_empty),
    .count_o(fifo_count)
  );

  host_byte_mux #(
    .W(SAMPLE_W),
    .B(HOST_W)
  ) u_host (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(start_go),
    .en_i   (!busy_o),
    .stb_i  (rd_stb_i),
    .word_i (fifo_head),
    .empty_i(fifo_empty),
    .data_o (host_data_o),
    .pop_o  (fifo_pop)
  );
endmodule

// File: rtl/adc_burst_buf_chk.sv
module adc_burst_buf_chk #(
  parameter int HOST_W   = 8,
  parameter int DEPTH    = 1024,
  parameter int DIV_SLOW = 100,
  parameter int DIV_FAST = 50
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       start_i,
  input logic                       busy_o,
  input logic                       adc_conv_o,
  input logic [HOST_W-1:0]          host_data_o,
  input logic                       rate_q,
  input logic                       fifo_full,
  input logic                       fifo_empty,
  input logic                       fifo_pop,
  input logic [$clog2(DEPTH+1)-1:0] fifo_count
);
  logic [15:0] gap_q;
  logic        seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      if (adc_conv_o)         gap_q <= 16'd1;
      else if (gap_q != '1)   gap_q <= gap_q + 1'b1;
      if (!busy_o)            seen_q <= 1'b0;
      else if (adc_conv_o)    seen_q <= 1'b1;
    end
  end

  a_r3_conv_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_conv_o |=> !adc_conv_o);

  a_r3_conv_period: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && adc_conv_o && seen_q) |->
      (gap_q == (rate_q ? 16'(DIV_FAST) : 16'(DIV_SLOW))));

  a_r2_start_launch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i) |=> (busy_o && adc_conv_o && fifo_empty));

  a_r5_stop_on_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && fifo_full) |=> !busy_o);

  a_r5_no_conv_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !adc_conv_o);

  a_r5_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_count <= ($clog2(DEPTH+1))'(DEPTH));

  a_r9_hold_while_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(host_data_o));

  always_ff @(posedge clk_i) begin
    if (rst_ni) begin
      a_r8_no_underflow: assert (!(fifo_pop && fifo_empty));
    end
  end
endmodule

bind adc_burst_buf adc_burst_buf_chk #(
  .HOST_W  (HOST_W),
  .DEPTH   (DEPTH),
  .DIV_SLOW(DIV_SLOW),
  .DIV_FAST(DIV_FAST)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .busy_o     (busy_o),
  .adc_conv_o (adc_conv_o),
  .host_data_o(host_data_o),
  .rate_q     (rate_q),
  .fifo_full  (fifo_full),
  .fifo_empty (fifo_empty),
  .fifo_pop   (fifo_pop),
  .fifo_count (fifo_count)
);

// File: tb/adc_burst_buf_tb_top.sv
module adc_burst_buf_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 16;
  localparam int DIV_SLOW   = 12;
  localparam int DIV_FAST   = 6;
  localparam int LATCH_DLY  = 3;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic        rate_sel_i = 1'b0;
  logic        busy_o;
  logic        adc_conv_o;
  logic [15:0] adc_data_i = '0;
  logic        rd_stb_i = 1'b0;
  logic [7:0]  host_data_o;

  int n_chk = 0;
  int n_err = 0;
  int cycles = 0;
  int seed = 0;
  int conv_cnt = 0;
  int gap = 0;
  int gap_min = 0;
  int gap_max = 0;
  bit gap_seen = 1'b0;

  adc_burst_buf #(
    .DEPTH    (DEPTH),
    .DIV_SLOW (DIV_SLOW),
    .DIV_FAST (DIV_FAST),
    .LATCH_DLY(LATCH_DLY)
  ) dut_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .rate_sel_i (rate_sel_i),
    .busy_o     (busy_o),
    .adc_conv_o (adc_conv_o),
    .adc_data_i (adc_data_i),
    .rd_stb_i   (rd_stb_i),
    .host_data_o(host_data_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  function automatic logic [15:0] pat(input int s, input int k);
    return 16'((s * 16'h1357) ^ (k * 16'h0A3D) ^ (k << 9) ^ 16'h8001);
  endfunction

  // ADC model and convert-pulse monitor
  always @(negedge clk_i) begin
    cycles++;
    if (rst_ni) begin
      if (adc_conv_o) begin
        adc_data_i <= pat(seed, conv_cnt);
        conv_cnt++;
        if (gap_seen) begin
          if (gap < gap_min) gap_min = gap;
          if (gap > gap_max) gap_max = gap;
        end
        gap = 1;
        gap_seen = 1'b1;
      end else begin
        gap++;
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic strobe(output logic [7:0] b);
    @(negedge clk_i);
    rd_stb_i = 1'b1;
    @(negedge clk_i);
    b = host_data_o;
    rd_stb_i = 1'b0;
    @(negedge clk_i);
  endtask

  task automatic start_cap(input int s, input logic rate);
    @(posedge clk_i);
    #1;
    seed = s;
    conv_cnt = 0;
    gap_seen = 1'b0;
    gap_min = 1 << 20;
    gap_max = 0;
    @(negedge clk_i);
    start_i = 1'b1;
    rate_sel_i = rate;
    @(negedge clk_i);
    start_i = 1'b0;
    rate_sel_i = ~rate;  // must not matter after start (R3)
    chk("R2 busy after start", int'(busy_o), 1);
  endtask

  task automatic wait_idle();
    while (busy_o) @(negedge clk_i);
  endtask

  task automatic drain_check(input int s, input string req);
    logic [7:0] b;
    logic [15:0] w;
    for (int k = 0; k < DEPTH; k++) begin
      w = pat(s, k);
      strobe(b);
      chk({req, " R4 R7 high byte"}, int'(b), int'(w[15:8]));
      strobe(b);
      chk({req, " R4 R7 low byte"}, int'(b), int'(w[7:0]));
    end
  endtask

  task automatic capture_run(input int s, input logic rate);
    logic [7:0] b;
    logic [7:0] hold;
    int d;
    d = rate ? DIV_FAST : DIV_SLOW;
    start_cap(s, rate);
    repeat (3 * d) @(negedge clk_i);
    // R6: second start mid-capture
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    chk("R6 busy held on mid start", int'(busy_o), 1);
    // R9: read strobe while busy
    hold = host_data_o;
    strobe(b);
    chk("R9 host byte held while busy", int'(b), int'(hold));
    wait_idle();
    chk("R5 convert pulse count", conv_cnt, DEPTH);
    chk("R3 period min", gap_min, d);
    chk("R3 period max", gap_max, d);
    repeat (2 * DIV_SLOW) @(negedge clk_i);
    chk("R5 no convert while idle", conv_cnt, DEPTH);
    drain_check(s, "full drain");
    strobe(b);
    chk("R8 empty read zero", int'(b), 0);
    strobe(b);
    chk("R8 repeat empty read zero", int'(b), 0);
  endtask

  initial begin : watchdog
    wait (cycles > 150000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin : main
    logic [7:0] b;
    repeat (3) @(negedge clk_i);
    chk("R1 reset busy", int'(busy_o), 0);
    chk("R1 reset conv", int'(adc_conv_o), 0);
    chk("R1 reset host byte", int'(host_data_o), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    strobe(b);
    chk("R1 R8 first read after reset", int'(b), 0);

    for (int r = 0; r < 2; r++) begin
      for (int s = 1; s <= 3; s++) begin
        capture_run(s * 7 + r, logic'(r));
      end
    end

    // R10: partial drain, odd number of bytes, then restart
    start_cap(41, 1'b1);
    wait_idle();
    for (int i = 0; i < 5; i++) strobe(b);
    start_cap(42, 1'b0);
    wait_idle();
    chk("R10 conv count after restart", conv_cnt, DEPTH);
    drain_check(42, "R10 flushed");
    strobe(b);
    chk("R10 R8 nothing left", int'(b), 0);

    // R1: reset in the middle of a capture
    start_cap(55, 1'b1);
    repeat (2 * DIV_FAST) @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    chk("R1 busy cleared by reset", int'(busy_o), 0);
    chk("R1 conv cleared by reset", int'(adc_conv_o), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    strobe(b);
    chk("R1 FIFO empty after reset", int'(b), 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule